// File: doc/BRIEF.md
# Serial Wire Debug host transaction engine

This block is the host end of a two-wire serial debug link. A controller hands it one command at a time: a register read, a register write, a line-reset pattern, the JTAG-to-SWD mode-switch pattern, or a batch close. The engine drives the serial clock and the data line. It switches the line's output enable around the turnaround slots, checks the target's acknowledge and the read parity, and returns a status code and, for reads, the data word.

Errors are sticky. A FAULT, an unknown acknowledge or a read parity mismatch latches a status. Every later read or write is then answered at once with that status and causes no bus activity. This lasts until a batch close returns the status and clears it. A WAIT acknowledge is handled without the controller's help: the engine writes the debug-port abort register to clear the target's sticky flags, then replays the original transaction.

Top module: `swd_host_engine`

## Requirements
- R1: Every read or write frame opens with an 8-bit request driven least-significant bit first. Bit 0 is 1 (start), bit 1 is the AP select, bit 2 is 1 for a read, bits 3 and 4 carry cmd_addr[0] and cmd_addr[1], bit 5 is the even parity of bits 1 to 4, bit 6 is 0 and bit 7 is 1.
- R2: Each bus bit takes two clk cycles, one with swclk low and then one with swclk high. swdio_o and swdio_oe change only in the low cycle. swdio_i is sampled at the clk edge that raises swclk.
- R3: After the request, a read releases the line (swdio_oe = 0) for 38 bits. These are one turnaround bit, a 3-bit acknowledge received least-significant bit first, 32 data bits least-significant bit first, one parity bit and one final turnaround bit.
- R4: After the request, a write releases the line for 5 bits (turnaround, 3-bit acknowledge, turnaround). It then drives 32 data bits least-significant bit first, followed by their even parity bit.
- R5: An acknowledge of 3'b001 (OK) on a read whose parity bit equals the XOR of the 32 data bits returns status 4'h0 and the data. If the parity does not match, the read returns status 4'h1 with rsp_rdata = 0, and 4'h1 is latched.
- R6: An acknowledge of 3'b010 (WAIT) triggers a debug-port write to address 0 with data 32'h0000_001E, whose own acknowledge is not acted on. The complete original frame is then sent again.
- R7: An acknowledge of 3'b100 (FAULT), or any code other than 001, 010 or 100, ends the transaction with status {1'b1, ack} (FAULT gives 4'hC) and latches that status.
- R8: While a nonzero status is latched, a read or write command is answered in the next cycle with that status and rsp_rdata = 0. swclk does not pulse.
- R9: After an AP access that completes OK, the engine clocks AP_EXTRA more bits with the line released before it responds.
- R10: A batch close clocks FLUSH_IDLE bits with the line released. It responds with the latched status and then clears the latch to 4'h0.
- R11: A line reset drives LR_BITS ones and then TAIL_IDLE zeros. The switch command drives LR_BITS ones, 16'hE79E least-significant bit first, LR_BITS ones and then TAIL_IDLE zeros. Both respond with the latched status and leave it unchanged.
- R12: During reset, swclk = 0, swdio_oe = 1, swdio_o = 0, cmd_ready = 1, rsp_valid = 0, and the latched status is 4'h0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; one bus bit spans two cycles |
| rst_n | input | 1 | Active-low synchronous reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Engine idle; a command is taken when both are high |
| cmd_op | input | 3 | 0 read, 1 write, 2 line reset, 3 switch to serial debug, 4 batch close |
| cmd_ap | input | 1 | 1 selects the access port, 0 the debug port |
| cmd_addr | input | 2 | Register address bits |
| cmd_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | One-cycle pulse when a command finishes |
| rsp_status | output | 4 | 0 OK, 1 parity error, {1, ack} acknowledge error |
| rsp_rdata | output | 32 | Read data, zero unless a read succeeded |
| swclk | output | 1 | Serial clock |
| swdio_o | output | 1 | Data driven toward the target |
| swdio_oe | output | 1 | Output enable of the data line |
| swdio_i | input | 1 | Data received from the line |

## Verification
A behavioural target model answers each frame, and the bench predicts every bus bit, output enable and response. Reads and writes to both port types show whether the request header, the turnaround slots and the extra access-port cycles are placed correctly. A WAIT answer on a read and on a write, with the abort frame itself answered by FAULT, separates a correct retry from one that acts on the abort's own acknowledge. Bad parity, FAULT, all-ones and all-zeros acknowledges are each followed by skipped commands, a sequence and batch closes, which shows that the error latch holds and then clears.

// File: rtl/swdh_pkg.sv
`timescale 1ns/1ps
package swdh_pkg;

    typedef enum logic [2:0] {
        OP_READ       = 3'd0,
        OP_WRITE      = 3'd1,
        OP_LINE_RESET = 3'd2,
        OP_TO_SWD     = 3'd3,
        OP_FLUSH      = 3'd4
    } swdh_op_e;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SEQ,
        ST_FRAME,
        ST_POST
    } swdh_state_e;

    localparam logic [2:0] ACK_OK    = 3'b001;
    localparam logic [2:0] ACK_WAIT  = 3'b010;
    localparam logic [2:0] ACK_FAULT = 3'b100;

    localparam logic [3:0] STAT_OK     = 4'h0;
    localparam logic [3:0] STAT_PARITY = 4'h1;

    // frame layout: request 0..7, released slots 8..12, write payload 13..45
    localparam int FRAME_BITS = 46;
    localparam int ACK_LO     = 9;
    localparam int DATA_LO    = 12;
    localparam int PAR_BIT    = 44;

    localparam logic [31:0] ABORT_CLEAR = 32'h0000_001E;

endpackage

// File: rtl/swdh_frame_build.sv
`timescale 1ns/1ps
module swdh_frame_build (
    input  logic        rnw,
    input  logic        ap,
    input  logic [1:0]  addr,
    input  logic [31:0] wdata,
    output logic [45:0] tx
);
    logic [7:0]  hdr;
    logic [31:0] payload;

    always_comb begin
        hdr     = {1'b1, 1'b0, ap ^ rnw ^ addr[0] ^ addr[1], addr[1], addr[0], rnw, ap, 1'b1};
        payload = rnw ? 32'h0 : wdata;
        tx      = {^payload, payload, 5'b0_0000, hdr};
    end
endmodule

// File: rtl/swdh_seq_bit.sv
`timescale 1ns/1ps
module swdh_seq_bit #(
    parameter int LR_BITS   = 50,
    parameter int TAIL_IDLE = 2,
    parameter int IDX_W     = 7
) (
    input  logic             is_switch,
    input  logic [IDX_W-1:0] idx,
    output logic             bit_o
);
    localparam logic [15:0] SWITCH_CODE = 16'hE79E;
    localparam logic [IDX_W-1:0] LR_END  = IDX_W'(LR_BITS);
    localparam logic [IDX_W-1:0] SW_END  = IDX_W'(LR_BITS + 16);
    localparam logic [IDX_W-1:0] LR2_END = IDX_W'(2 * LR_BITS + 16);

    logic [IDX_W-1:0] off;

    always_comb begin
        off = idx - LR_END;
        if (idx < LR_END)           bit_o = 1'b1;
        else if (!is_switch)        bit_o = 1'b0;
        else if (idx < SW_END)      bit_o = SWITCH_CODE[off[3:0]];
        else if (idx < LR2_END)     bit_o = 1'b1;
        else                        bit_o = 1'b0;
    end
endmodule

// File: rtl/swd_host_engine.sv
`timescale 1ns/1ps
module swd_host_engine
    import swdh_pkg::*;
#(
    parameter int LR_BITS    = 50,
    parameter int TAIL_IDLE  = 2,
    parameter int AP_EXTRA   = 3,
    parameter int FLUSH_IDLE = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cmd_valid,
    output logic        cmd_ready,
    input  logic [2:0]  cmd_op,
    input  logic        cmd_ap,
    input  logic [1:0]  cmd_addr,
    input  logic [31:0] cmd_wdata,
    output logic        rsp_valid,
    output logic [3:0]  rsp_status,
    output logic [31:0] rsp_rdata,
    output logic        swclk,
    output logic        swdio_o,
    output logic        swdio_oe,
    input  logic        swdio_i
);
    localparam int SW_LEN = 2 * LR_BITS + 16 + TAIL_IDLE;
    localparam int LR_LEN = LR_BITS + TAIL_IDLE;
    localparam int MAX_A  = (SW_LEN > FLUSH_IDLE) ? SW_LEN : FLUSH_IDLE;
    localparam int MAX_B  = (MAX_A > AP_EXTRA) ? MAX_A : AP_EXTRA;
    localparam int MAX_C  = (MAX_B > 64) ? MAX_B : 64;
    localparam int CNT_W  = $clog2(MAX_C + 1);

    typedef struct packed {
        swdh_state_e state;
        logic        phase;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] limit;
        logic        is_switch;
        logic        is_flush;
        logic        in_abort;
        logic        cur_rnw;
        logic        orig_rnw;
        logic        orig_ap;
        logic [1:0]  orig_addr;
        logic [31:0] orig_wdata;
        logic [45:0] tx;
        logic [45:0] rx;
        logic [3:0]  err;
        logic        rsp_valid;
        logic [3:0]  rsp_status;
        logic [31:0] rsp_rdata;
    } regs_t;

    regs_t r_q, r_d;

    logic [45:0] tx_cmd, tx_orig, tx_abort;
    logic        seq_bit;
    logic [5:0]  fidx;
    logic        last_bit;
    logic [2:0]  ack;
    logic [31:0] rdat;
    logic        rpar;
    logic        frame_oe;
    swdh_op_e    op_e;

    swdh_frame_build u_build_cmd (
        .rnw(cmd_op == OP_READ), .ap(cmd_ap), .addr(cmd_addr), .wdata(cmd_wdata), .tx(tx_cmd)
    );
    swdh_frame_build u_build_orig (
        .rnw(r_q.orig_rnw), .ap(r_q.orig_ap), .addr(r_q.orig_addr), .wdata(r_q.orig_wdata), .tx(tx_orig)
    );
    swdh_frame_build u_build_abort (
        .rnw(1'b0), .ap(1'b0), .addr(2'b00), .wdata(ABORT_CLEAR), .tx(tx_abort)
    );
    swdh_seq_bit #(.LR_BITS(LR_BITS), .TAIL_IDLE(TAIL_IDLE), .IDX_W(CNT_W)) u_seq (
        .is_switch(r_q.is_switch), .idx(r_q.cnt), .bit_o(seq_bit)
    );

    always_comb begin
        r_d          = r_q;
        r_d.rsp_valid = 1'b0;
        op_e     = swdh_op_e'(cmd_op);
        fidx     = r_q.cnt[5:0];
        last_bit = (r_q.cnt == r_q.limit - 1'b1);
        ack      = r_q.rx[ACK_LO +: 3];
        rdat     = r_q.rx[DATA_LO +: 32];
        rpar     = r_q.rx[PAR_BIT];
        case (r_q.state)
            ST_IDLE: begin
                if (cmd_valid) begin
                    r_d.phase    = 1'b0;
                    r_d.cnt      = '0;
                    r_d.is_flush = 1'b0;
                    case (op_e)
                        OP_READ, OP_WRITE: begin
                            if (r_q.err != STAT_OK) begin
                                r_d.rsp_valid  = 1'b1;
                                r_d.rsp_status = r_q.err;
                                r_d.rsp_rdata  = '0;
                            end else begin
                                r_d.orig_rnw   = (op_e == OP_READ);
                                r_d.cur_rnw    = (op_e == OP_READ);
                                r_d.orig_ap    = cmd_ap;
                                r_d.orig_addr  = cmd_addr;
                                r_d.orig_wdata = cmd_wdata;
                                r_d.in_abort   = 1'b0;
                                r_d.tx         = tx_cmd;
                                r_d.limit      = CNT_W'(FRAME_BITS);
                                r_d.state      = ST_FRAME;
                            end
                        end
                        OP_LINE_RESET: begin
                            r_d.is_switch = 1'b0;
                            r_d.limit     = CNT_W'(LR_LEN);
                            r_d.state     = ST_SEQ;
                        end
                        OP_TO_SWD: begin
                            r_d.is_switch = 1'b1;
                            r_d.limit     = CNT_W'(SW_LEN);
                            r_d.state     = ST_SEQ;
                        end
                        OP_FLUSH: begin
                            r_d.is_flush = 1'b1;
                            r_d.limit    = CNT_W'(FLUSH_IDLE);
                            r_d.state    = ST_POST;
                        end
                        default: ;
                    endcase
                end
            end
            default: begin
                if (!r_q.phase) begin
                    r_d.phase = 1'b1;
                    if (r_q.state == ST_FRAME) r_d.rx[fidx] = swdio_i;
                end else begin
                    r_d.phase = 1'b0;
                    if (!last_bit) begin
                        r_d.cnt = r_q.cnt + 1'b1;
                    end else begin
                        r_d.cnt = '0;
                        case (r_q.state)
                            ST_FRAME: begin
                                if (r_q.in_abort) begin
                                    r_d.in_abort = 1'b0;
                                    r_d.cur_rnw  = r_q.orig_rnw;
                                    r_d.tx       = tx_orig;
                                end else if (ack == ACK_WAIT) begin
                                    r_d.in_abort = 1'b1;
                                    r_d.cur_rnw  = 1'b0;
                                    r_d.tx       = tx_abort;
                                end else if (ack == ACK_OK && r_q.orig_rnw && (rpar != ^rdat)) begin
                                    r_d.err        = STAT_PARITY;
                                    r_d.rsp_status = STAT_PARITY;
                                    r_d.rsp_rdata  = '0;
                                    r_d.rsp_valid  = 1'b1;
                                    r_d.state      = ST_IDLE;
                                end else if (ack == ACK_OK) begin
                                    r_d.rsp_status = STAT_OK;
                                    r_d.rsp_rdata  = r_q.orig_rnw ? rdat : 32'h0;
                                    if (r_q.orig_ap && AP_EXTRA > 0) begin
                                        r_d.limit = CNT_W'(AP_EXTRA);
                                        r_d.state = ST_POST;
                                    end else begin
                                        r_d.rsp_valid = 1'b1;
                                        r_d.state     = ST_IDLE;
                                    end
                                end else begin
                                    r_d.err        = {1'b1, ack};
                                    r_d.rsp_status = {1'b1, ack};
                                    r_d.rsp_rdata  = '0;
                                    r_d.rsp_valid  = 1'b1;
                                    r_d.state      = ST_IDLE;
                                end
                            end
                            ST_POST: begin
                                r_d.rsp_valid = 1'b1;
                                r_d.state     = ST_IDLE;
                                if (r_q.is_flush) begin
                                    r_d.rsp_status = r_q.err;
                                    r_d.rsp_rdata  = '0;
                                    r_d.err        = STAT_OK;
                                end
                            end
                            default: begin
                                r_d.rsp_valid  = 1'b1;
                                r_d.rsp_status = r_q.err;
                                r_d.rsp_rdata  = '0;
                                r_d.state      = ST_IDLE;
                            end
                        endcase
                    end
                end
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            r_q       <= '0;
            r_q.state <= ST_IDLE;
            r_q.err   <= STAT_OK;
        end else begin
            r_q <= r_d;
        end
    end

    always_comb begin
        frame_oe = (fidx < 6'd8) || (!r_q.cur_rnw && fidx >= 6'd13);
        swclk    = 1'b0;
        swdio_oe = 1'b1;
        swdio_o  = 1'b0;
        case (r_q.state)
            ST_SEQ: begin
                swclk   = r_q.phase;
                swdio_o = seq_bit;
            end
            ST_FRAME: begin
                swclk    = r_q.phase;
                swdio_oe = frame_oe;
                swdio_o  = frame_oe & r_q.tx[fidx];
            end
            ST_POST: begin
                swclk    = r_q.phase;
                swdio_oe = 1'b0;
            end
            default: ;
        endcase
    end

    assign cmd_ready  = (r_q.state == ST_IDLE);
    assign rsp_valid  = r_q.rsp_valid;
    assign rsp_status = r_q.rsp_status;
    assign rsp_rdata  = r_q.rsp_rdata;

    // R2
    clk_high_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swclk |=> !swclk);

    // R2
    line_steady_high_chk: assert property (@(posedge clk) disable iff (!rst_n)
        swclk |-> ($stable(swdio_o) && $stable(swdio_oe)));

    // R8
    skip_no_bus_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_ready && r_q.err != STAT_OK &&
         (cmd_op == OP_READ || cmd_op == OP_WRITE))
        |=> (rsp_valid && !swclk && rsp_status == $past(r_q.err)));

    // R5
    fail_no_data_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && rsp_status != STAT_OK) |-> (rsp_rdata == 32'h0));

    // R7
    err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (r_q.err != STAT_OK && r_q.state != ST_POST) |=> $stable(r_q.err));

    // R10
    flush_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_valid && r_q.is_flush) |-> (r_q.err == STAT_OK));

endmodule

// File: tb/swd_host_engine_tb.sv
`timescale 1ns/1ps
module swd_host_engine_tb;
    import swdh_pkg::*;

    localparam int LR  = 50;
    localparam int TL  = 2;
    localparam int APX = 3;
    localparam int FLX = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cmd_valid = 1'b0;
    logic cmd_ready;
    logic [2:0] cmd_op = 3'd0;
    logic cmd_ap = 1'b0;
    logic [1:0] cmd_addr = 2'd0;
    logic [31:0] cmd_wdata = 32'h0;
    logic rsp_valid;
    logic [3:0] rsp_status;
    logic [31:0] rsp_rdata;
    logic swclk, swdio_o, swdio_oe;
    logic swdio_i = 1'b0;

    always #2.5 clk = ~clk;

    swd_host_engine #(.LR_BITS(LR), .TAIL_IDLE(TL), .AP_EXTRA(APX), .FLUSH_IDLE(FLX)) u_dut (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
        .cmd_op(cmd_op), .cmd_ap(cmd_ap), .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata),
        .rsp_valid(rsp_valid), .rsp_status(rsp_status), .rsp_rdata(rsp_rdata),
        .swclk(swclk), .swdio_o(swdio_o), .swdio_oe(swdio_oe), .swdio_i(swdio_i)
    );

    bit q_oe[$];
    bit q_o[$];
    bit q_in[$];
    int n_checks = 0;
    int n_fail = 0;
    int cyc = 0;
    logic prev_sw = 1'b0;
    logic prev_oe = 1'b1;
    logic prev_o = 1'b0;

    task automatic check(bit ok, string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic push(bit oe, bit o, bit in);
        q_oe.push_back(oe);
        q_o.push_back(o);
        q_in.push_back(in);
    endtask

    // R1 header model
    task automatic add_req(bit rnw, bit ap, bit [1:0] a);
        push(1, 1, 0); push(1, ap, 0); push(1, rnw, 0);
        push(1, a[0], 0); push(1, a[1], 0);
        push(1, ap ^ rnw ^ a[0] ^ a[1], 0);
        push(1, 0, 0); push(1, 1, 0);
    endtask

    task automatic add_rel(int n);
        for (int i = 0; i < n; i++) push(0, 0, 0);
    endtask

    task automatic add_read(bit ap, bit [1:0] a, bit [2:0] ackv, bit [31:0] d, bit badpar);
        add_req(1, ap, a);
        push(0, 0, 0);
        for (int i = 0; i < 3; i++) push(0, 0, ackv[i]);
        for (int i = 0; i < 32; i++) push(0, 0, d[i]);
        push(0, 0, (^d) ^ badpar);
        push(0, 0, 0);
    endtask

    task automatic add_write(bit ap, bit [1:0] a, bit [2:0] ackv, bit [31:0] d);
        add_req(0, ap, a);
        push(0, 0, 0);
        for (int i = 0; i < 3; i++) push(0, 0, ackv[i]);
        push(0, 0, 0);
        for (int i = 0; i < 32; i++) push(1, d[i], 0);
        push(1, ^d, 0);
    endtask

    task automatic add_seq(bit sw);
        bit [15:0] code = 16'hE79E;
        for (int i = 0; i < LR; i++) push(1, 1, 0);
        if (sw) begin
            for (int i = 0; i < 16; i++) push(1, code[i], 0);
            for (int i = 0; i < LR; i++) push(1, 1, 0);
        end
        for (int i = 0; i < TL; i++) push(1, 0, 0);
    endtask

    task automatic run(logic [2:0] op, bit ap, bit [1:0] a, bit [31:0] wd,
                       logic [3:0] exp_st, logic [31:0] exp_rd, string tag);
        bit got = 0;
        int guard = 0;
        bit e_oe, e_o;
        @(negedge clk);
        cmd_op = op; cmd_ap = ap; cmd_addr = a; cmd_wdata = wd; cmd_valid = 1'b1;
        @(negedge clk);
        cmd_valid = 1'b0;
        while (!got && guard < 20000) begin
            if (swclk && prev_sw) check(0, {tag, " R2 clock high too long"}, 1, 0);
            if (swclk && !prev_sw) begin
                check(swdio_oe == prev_oe && swdio_o == prev_o, {tag, " R2 line moved at rise"},
                      {30'h0, swdio_oe, swdio_o}, {30'h0, prev_oe, prev_o});
                if (q_oe.size() == 0) begin
                    check(0, {tag, " unexpected bus bit"}, 1, 0);
                end else begin
                    e_oe = q_oe.pop_front();
                    e_o  = q_o.pop_front();
                    void'(q_in.pop_front());
                    check(swdio_oe == e_oe && (!e_oe || swdio_o == e_o), {tag, " bus bit"},
                          {30'h0, swdio_oe, swdio_o}, {30'h0, e_oe, e_o});
                    swdio_i = (q_in.size() > 0) ? q_in[0] : 1'b0;
                end
            end
            prev_sw = swclk; prev_oe = swdio_oe; prev_o = swdio_o;
            if (rsp_valid) got = 1;
            else begin
                @(negedge clk);
                guard++;
            end
        end
        check(got, {tag, " response seen"}, {31'h0, got}, 1);
        check(q_oe.size() == 0, {tag, " bits left over"}, q_oe.size(), 0);
        check(rsp_status == exp_st, {tag, " status"}, {28'h0, rsp_status}, {28'h0, exp_st});
        check(rsp_rdata == exp_rd, {tag, " rdata"}, rsp_rdata, exp_rd);
        q_oe.delete(); q_o.delete(); q_in.delete();
        swdio_i = 1'b0;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            check(0, "watchdog", cyc, 150000);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12
        check(swclk == 1'b0 && swdio_oe == 1'b1 && swdio_o == 1'b0, "R12 bus at reset",
              {29'h0, swclk, swdio_oe, swdio_o}, 32'h2);
        check(cmd_ready == 1'b1 && rsp_valid == 1'b0, "R12 handshake at reset",
              {30'h0, cmd_ready, rsp_valid}, 32'h2);
        rst_n = 1'b1;

        add_seq(0); run(OP_LINE_RESET, 0, 0, 0, 4'h0, 0, "R11 line reset");
        add_seq(1); run(OP_TO_SWD, 0, 0, 0, 4'h0, 0, "R11 switch");

        add_read(0, 1, 3'b001, 32'hA5A5_1234, 0);
        run(OP_READ, 0, 1, 0, 4'h0, 32'hA5A5_1234, "R1 R3 R5 dp read");

        add_write(1, 3, 3'b001, 32'h8000_0001); add_rel(APX);
        run(OP_WRITE, 1, 3, 32'h8000_0001, 4'h0, 0, "R4 R9 ap write");

        add_read(1, 2, 3'b001, 32'h0, 0); add_rel(APX);
        run(OP_READ, 1, 2, 0, 4'h0, 0, "R9 ap read");

        // R6 abort acknowledged with FAULT is not acted on
        add_write(0, 2, 3'b010, 32'h0000_00F0);
        add_write(0, 0, 3'b100, 32'h0000_001E);
        add_write(0, 2, 3'b001, 32'h0000_00F0);
        run(OP_WRITE, 0, 2, 32'h0000_00F0, 4'h0, 0, "R6 write wait");

        add_read(1, 0, 3'b010, 32'h1111_2222, 0);
        add_write(0, 0, 3'b001, 32'h0000_001E);
        add_read(1, 0, 3'b001, 32'hDEAD_BEEF, 0); add_rel(APX);
        run(OP_READ, 1, 0, 0, 4'h0, 32'hDEAD_BEEF, "R6 read wait");

        add_read(0, 3, 3'b001, 32'h0F0F_0001, 1);
        run(OP_READ, 0, 3, 0, 4'h1, 0, "R5 bad parity");
        run(OP_READ, 0, 1, 0, 4'h1, 0, "R8 skip read");
        run(OP_WRITE, 1, 1, 32'h5, 4'h1, 0, "R8 skip write");
        add_rel(FLX); run(OP_FLUSH, 0, 0, 0, 4'h1, 0, "R10 flush");
        add_rel(FLX); run(OP_FLUSH, 0, 0, 0, 4'h0, 0, "R10 flush cleared");

        add_write(1, 1, 3'b100, 32'h0000_1234);
        run(OP_WRITE, 1, 1, 32'h0000_1234, 4'hC, 0, "R7 fault");
        add_seq(0); run(OP_LINE_RESET, 0, 0, 0, 4'hC, 0, "R11 reset keeps status");
        run(OP_READ, 1, 1, 0, 4'hC, 0, "R8 skip after fault");
        add_rel(FLX); run(OP_FLUSH, 0, 0, 0, 4'hC, 0, "R10 flush fault");

        add_read(0, 0, 3'b111, 32'h55, 0);
        run(OP_READ, 0, 0, 0, 4'hF, 0, "R7 ack all ones");
        add_rel(FLX); run(OP_FLUSH, 0, 0, 0, 4'hF, 0, "R10 flush junk");

        add_write(0, 1, 3'b000, 32'h77);
        run(OP_WRITE, 0, 1, 32'h77, 4'h8, 0, "R7 no answer");
        add_rel(FLX); run(OP_FLUSH, 0, 0, 0, 4'h8, 0, "R10 flush silent");

        add_read(0, 2, 3'b001, 32'h1357_2468, 0);
        run(OP_READ, 0, 2, 0, 4'h0, 32'h1357_2468, "R5 read after clear");

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule